// File: doc/BRIEF.md
# Event-Driven Sampling Rate Scheduler

This block sits on the timer side of a digitizer and decides when its samples are taken. It watches a stream of 16-bit event codes that arrive from a timing network, each with a one-cycle valid strobe. A table of up to eight entries holds the codes it responds to. Each entry has its own delay and window length.

When no window is open, the block sends single-cycle sample strobes at a slow base rate. These come from a programmable divider of the reference clock. When a listed code arrives, the block waits the entry's delay and then switches the strobe to a fast divider for the entry's window length. After the window it returns to the base rate.

Every accepted event produces a one-cycle record. The record holds:
- the code,
- a time tag counted in reference-clock cycles since reset,
- the sampling rate that was active when the event arrived.

Several units that share the reference clock and the event stream therefore produce strobes and records that match cycle for cycle.

Top module: `evt_rate_sched`

## Requirements
- R1: While reset is asserted, `fast_mode` and `rec_valid` are 0 and `rec_time` is 0.
- R2: At the base rate with divisor value B (0 is treated as 1), `samp_stb` is a one-cycle pulse in cycles B-1, 2B-1, … counted from the first cycle after reset, or from the first cycle after a rate change.
- R3: An event is accepted only when `ev_valid` is 1 and `ev_code` equals the code of an entry whose enable bit is set. An event with any other code, or one that matches only disabled entries, produces no record and does not change `fast_mode`.
- R4: When several enabled entries hold the same code, the entry with the lowest index supplies the delay and the window. Entry i occupies bits [16*i+15:16*i] of the code vector and bits [24*i+23:24*i] of the delay and window vectors.
- R5: Suppose an event is accepted at the clock edge that ends cycle c while no window is open. Then `fast_mode` is 1 from cycle c+1+D, where D is the entry's delay.
- R6: A window lasts W cycles, where W is the entry's window length and 0 is treated as 1. After that, `fast_mode` returns to 0.
- R7: An accepted event that arrives while `fast_mode` is 1 restarts the window with the new entry's length, starting in the next cycle with no delay applied. The event is still recorded.
- R8: An accepted event that arrives while a delay is running discards the pending delay and starts the new entry's delay and window.
- R9: An event accepted in cycle c produces, in cycle c+1, `rec_valid`=1 with `rec_code` set to the event code, `rec_time`=c (cycle 0 is the first cycle after reset is released) and `rec_fast` equal to the value of `fast_mode` in cycle c.
- R10: While `fast_mode` is 1, with fast divisor F (0 is treated as 1), `samp_stb` pulses in cycles F-1, 2F-1, … counted from the first cycle of the window. The divider phase restarts at every rate change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event code strobe |
| ev_code | input | 16 | Decoded event number |
| base_div | input | 16 | Base-rate divisor |
| fast_div | input | 16 | Fast-rate divisor |
| ent_en | input | 8 | Per-entry enable |
| ent_code | input | 128 | Entry codes, 16 bits each |
| ent_delay | input | 192 | Entry delays in cycles, 24 bits each |
| ent_win | input | 192 | Entry window lengths in cycles, 24 bits each |
| samp_stb | output | 1 | Single-cycle sample strobe |
| fast_mode | output | 1 | High while the fast rate is active |
| rec_valid | output | 1 | Event record strobe |
| rec_code | output | 16 | Recorded event code |
| rec_time | output | 32 | Recorded time tag |
| rec_fast | output | 1 | Rate that was active when the event arrived |

## Verification
The record is due exactly one cycle after the accepting edge. The rate flag changes D+1 cycles after the accepting edge, or one cycle after it for a retrigger. The strobe follows from the cycle distance to the most recent rate change.

The bench keeps a per-cycle model built from these rules: window start and end cycles, the last rate-change cycle and a pending record. It drives inputs at the falling edge and compares every output in the same half cycle, so each comparison lands in the cycle in which the result is due.

// File: rtl/evt_rate_sched.sv
module evt_rate_sched #(
  parameter int CODE_W = 16,
  parameter int N_ENT  = 8,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 24,
  parameter int TIME_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  input  logic [CODE_W-1:0]       ev_code,
  input  logic [DIV_W-1:0]        base_div,
  input  logic [DIV_W-1:0]        fast_div,
  input  logic [N_ENT-1:0]        ent_en,
  input  logic [N_ENT*CODE_W-1:0] ent_code,
  input  logic [N_ENT*CNT_W-1:0]  ent_delay,
  input  logic [N_ENT*CNT_W-1:0]  ent_win,
  output logic                    samp_stb,
  output logic                    fast_mode,
  output logic                    rec_valid,
  output logic [CODE_W-1:0]       rec_code,
  output logic [TIME_W-1:0]       rec_time,
  output logic                    rec_fast
);

  typedef enum logic [1:0] {ST_BASE, ST_WAIT, ST_FAST} st_t;

  st_t              st, st_n;
  logic [CNT_W-1:0] dcnt, dcnt_n, wcnt, wcnt_n, wpend, wpend_n;
  logic [TIME_W-1:0] tstamp;
  logic [DIV_W-1:0] divcnt, period, plast;

  logic             hit;
  logic [CNT_W-1:0] hit_d, hit_w, hit_wm1;

  always_comb begin
    hit   = 1'b0;
    hit_d = '0;
    hit_w = '0;
    for (int i = N_ENT-1; i >= 0; i--) begin
      if (ent_en[i] && ent_code[i*CODE_W +: CODE_W] == ev_code) begin
        hit   = ev_valid;
        hit_d = ent_delay[i*CNT_W +: CNT_W];
        hit_w = ent_win[i*CNT_W +: CNT_W];
      end
    end
  end

  assign hit_wm1 = (hit_w == '0) ? '0 : hit_w - 1'b1;

  always_comb begin
    st_n    = st;
    dcnt_n  = dcnt;
    wcnt_n  = wcnt;
    wpend_n = wpend;
    case (st)
      ST_FAST: begin
        if (hit)               wcnt_n = hit_wm1;
        else if (wcnt == '0)   st_n   = ST_BASE;
        else                   wcnt_n = wcnt - 1'b1;
      end
      default: begin
        if (hit) begin
          if (hit_d == '0) begin
            st_n   = ST_FAST;
            wcnt_n = hit_wm1;
          end else begin
            st_n    = ST_WAIT;
            dcnt_n  = hit_d - 1'b1;
            wpend_n = hit_wm1;
          end
        end else if (st == ST_WAIT) begin
          if (dcnt == '0) begin
            st_n   = ST_FAST;
            wcnt_n = wpend;
          end else begin
            dcnt_n = dcnt - 1'b1;
          end
        end
      end
    endcase
  end

  assign fast_mode = (st == ST_FAST);
  assign period    = fast_mode ? fast_div : base_div;
  assign plast     = (period == '0) ? '0 : period - 1'b1;
  assign samp_stb  = (divcnt >= plast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_BASE;
      dcnt      <= '0;
      wcnt      <= '0;
      wpend     <= '0;
      divcnt    <= '0;
      tstamp    <= '0;
      rec_valid <= 1'b0;
      rec_code  <= '0;
      rec_time  <= '0;
      rec_fast  <= 1'b0;
    end else begin
      st        <= st_n;
      dcnt      <= dcnt_n;
      wcnt      <= wcnt_n;
      wpend     <= wpend_n;
      tstamp    <= tstamp + 1'b1;
      if ((st_n == ST_FAST) != fast_mode || samp_stb) divcnt <= '0;
      else                                            divcnt <= divcnt + 1'b1;
      rec_valid <= hit;
      if (hit) begin
        rec_code <= ev_code;
        rec_time <= tstamp;
        rec_fast <= fast_mode;
      end
    end
  end

  AST_REC_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(ev_valid));  // R9
  AST_REC_TIME_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_time == tstamp - 1'b1);  // R9
  AST_FAST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_mode) |-> ($past(st) == ST_WAIT || $past(hit)));  // R5
  AST_FAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_mode) |-> ($past(wcnt) == '0 && !$past(hit)));  // R6
  AST_NO_IDLE_DRIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_BASE && !$past(hit)) |-> st == ST_BASE);  // R3
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_mode != $past(fast_mode)) |-> (!samp_stb || plast == '0));  // R10

endmodule

// File: tb/test_evt_rate_sched.sv
module test_evt_rate_sched;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ev_valid = 1'b0;
  logic [15:0]  ev_code = '0;
  logic [15:0]  base_div, fast_div;
  logic [7:0]   ent_en;
  logic [127:0] ent_code;
  logic [191:0] ent_delay, ent_win;
  logic         samp_stb, fast_mode, rec_valid, rec_fast;
  logic [15:0]  rec_code;
  logic [31:0]  rec_time;

  logic [15:0] t_code [8];
  int          t_del  [8];
  int          t_win  [8];

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      ent_code[i*16 +: 16]  = t_code[i];
      ent_delay[i*24 +: 24] = t_del[i][23:0];
      ent_win[i*24 +: 24]   = t_win[i][23:0];
    end
  end

  evt_rate_sched i_evt_rate_sched (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .base_div(base_div), .fast_div(fast_div), .ent_en(ent_en),
    .ent_code(ent_code), .ent_delay(ent_delay), .ent_win(ent_win),
    .samp_stb(samp_stb), .fast_mode(fast_mode), .rec_valid(rec_valid),
    .rec_code(rec_code), .rec_time(rec_time), .rec_fast(rec_fast)
  );

  int total = 0, bad = 0;
  int c, fstart, fend, seg;
  bit prev_fast, er_v, er_fast;
  int er_code, er_time;
  string ftag = "R5";

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lookup(input logic [15:0] cd);
    for (int i = 0; i < 8; i++) if (ent_en[i] && t_code[i] == cd) return i;
    return -1;
  endfunction

  function automatic int per(input logic [15:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "fast_mode in reset", fast_mode, 0);
    chk("R1", "rec_valid in reset", rec_valid, 0);
    chk("R1", "rec_time in reset", rec_time, 0);
    rst_n = 1'b1;
    c = 0; fstart = 0; fend = 0; seg = 0; prev_fast = 0; er_v = 0;
  endtask

  task automatic step(input bit v, input logic [15:0] code);
    bit ef, es, acc;
    int p, idx, w;
    ef = (c >= fstart) && (c < fend);
    if (c > 0 && ef != prev_fast) seg = c;
    p  = ef ? per(fast_div) : per(base_div);
    es = ((c - seg) % p) == (p - 1);
    chk(ftag, "fast_mode", fast_mode, ef);
    chk(ef ? "R10" : "R2", "samp_stb", samp_stb, es);
    chk(er_v ? "R9" : "R3", "rec_valid", rec_valid, er_v);
    if (er_v) begin
      chk("R9", "rec_code", rec_code, er_code);
      chk("R9", "rec_time", rec_time, er_time);
      chk("R9", "rec_fast", rec_fast, er_fast);
    end
    ev_valid = v; ev_code = code;
    idx = lookup(code);
    acc = v && (idx >= 0);
    er_v = acc;
    if (acc) begin
      er_code = code; er_time = c; er_fast = ef;
      w = (t_win[idx] == 0) ? 1 : t_win[idx];
      if (ef) fend = c + 1 + w;
      else begin
        fstart = c + 1 + t_del[idx];
        fend   = fstart + w;
      end
    end
    prev_fast = ef;
    c++;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    t_code[0] = 16'h1234; t_del[0] = 3; t_win[0] = 6;
    t_code[1] = 16'hBEEF; t_del[1] = 0; t_win[1] = 4;
    t_code[2] = 16'h00A5; t_del[2] = 5; t_win[2] = 0;
    t_code[3] = 16'h7777; t_del[3] = 1; t_win[3] = 3;
    t_code[4] = 16'h1234; t_del[4] = 1; t_win[4] = 2;
    for (int i = 5; i < 8; i++) begin
      t_code[i] = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
      t_del[i]  = $urandom_range(0, 7);
      t_win[i]  = $urandom_range(0, 15);
    end
    ent_en = 8'b1111_0111;
    base_div = 16'd5; fast_div = 16'd2;

    do_reset();
    ftag = "R2";  idle(12);
    ftag = "R4";  step(1'b1, 16'h1234); idle(12);
    ftag = "R3";  step(1'b1, 16'h7777); idle(3); step(1'b1, 16'h4321); idle(3);
    ftag = "R8";  step(1'b1, 16'h00A5); idle(2); step(1'b1, 16'h00A5); idle(10);
    ftag = "R7";  step(1'b1, 16'hBEEF); idle(2); step(1'b1, 16'hBEEF); idle(8);
    step(1'b1, 16'hBEEF); step(1'b1, 16'hBEEF); idle(8);
    ftag = "R6";  step(1'b1, 16'h00A5); idle(10);

    for (int ph = 0; ph < 3; ph++) begin
      base_div = 16'($urandom_range(0, 9));
      fast_div = 16'($urandom_range(0, 3));
      do_reset();
      ftag = "R6";
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(0, 11) == 0) begin
          if ($urandom_range(0, 9) < 7) step(1'b1, t_code[$urandom_range(0, 7)]);
          else                          step(1'b1, 16'($urandom_range(0, 16'hFFFF)));
        end else begin
          step(1'b0, 16'h0);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule